// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm and Interrupt Registers

This block keeps wall-clock time as a day count plus hours, minutes and seconds, and holds a matching alarm time. A free-running sub-second strobe from an external prescaler drives it. After a set number of strobes, one second has passed. Seconds, minutes and hours wrap at their natural limits, and the day counter picks up the carry out of the hour counter. Software reaches all state through a simple 16-bit register port with word-aligned byte offsets. Reads are combinational, and writes take effect at the next clock edge.

When the counter reaches the programmed alarm time at a second boundary, an alarm flag is raised. A once-per-second flag and a flag from an external periodic strobe share the same status register, which software clears by writing ones. A separate mask register selects which flags drive the single interrupt line.

Top module: `rtc_tod_regs`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: Offset 0x00 holds hour in bits 12:8 and minute in bits 5:0, offset 0x04 holds seconds in bits 5:0, and offset 0x20 holds the day in bits DAY_W-1:0. A write to any of them reads back its value from the next cycle.
- R3: While bit 7 of the control register at offset 0x10 is set, every TICKS_PER_SEC pulses of `sub_tick` advance the time by one second. While that bit is clear, the time holds.
- R4: Seconds wrap from 59 to 0 with a carry into minutes, minutes wrap from 59 to 0 with a carry into hours, and hours wrap from 23 to 0 with a carry into the day. The day wraps from 2^DAY_W-1 to 0. A field loaded above its limit wraps to 0 at its next increment.
- R5: A seconds write restarts the sub-second phase, so a full TICKS_PER_SEC pulses pass before the next increment. In a cycle that writes any time register, `sub_tick` is dropped.
- R6: The alarm registers are read-write and use the same layouts as the time registers: alarm hour/minute at 0x08, alarm seconds at 0x0C and alarm day at 0x24.
- R7: Status bit 2 is set once, in the cycle after a second boundary at which day, hour, minute and second all equal the alarm values. It is not set again while the time stays matched.
- R8: Status bit 4 is set after every second boundary, and status bit 7 is set after a `periodic_tick` pulse. Status bit 0 and all other status bits read zero.
- R9: Writing 1 to a status bit at offset 0x14 clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R10: The enable register at offset 0x18 holds bits 2, 4 and 7 only. `irq` is high exactly while some status bit and its enable bit are both set.
- R11: Any other offset, including 0x1C and offsets that are not word aligned, reads zero and ignores writes. `bus_rdata` is zero while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | Sub-second strobe from the prescaler, one cycle wide |
| periodic_tick | input | 1 | Periodic event strobe that sets status bit 7 |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write qualifier for the access (1 = write) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the addressed register |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with TICKS_PER_SEC = 3 and DAY_W = 9. With a short phase, a seconds write can land at every phase position within a few cycles. With a 9-bit day, the wrap from 511 to 0 can be reached by a single write. Directed runs then cover the full 23:59:59 to next-day carry, the alarm firing once and not repeating, and the race between a status clear and a new set event. A long random run then mixes writes to every offset with running and stopped periods.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

   localparam int unsigned BUS_AW = 6;
   localparam int unsigned BUS_DW = 16;

   localparam logic [BUS_AW-1:0] OFS_TIME_HM  = 6'h00;
   localparam logic [BUS_AW-1:0] OFS_TIME_SEC = 6'h04;
   localparam logic [BUS_AW-1:0] OFS_ALM_HM   = 6'h08;
   localparam logic [BUS_AW-1:0] OFS_ALM_SEC  = 6'h0C;
   localparam logic [BUS_AW-1:0] OFS_CTRL     = 6'h10;
   localparam logic [BUS_AW-1:0] OFS_STAT     = 6'h14;
   localparam logic [BUS_AW-1:0] OFS_IEN      = 6'h18;
   localparam logic [BUS_AW-1:0] OFS_TIME_DAY = 6'h20;
   localparam logic [BUS_AW-1:0] OFS_ALM_DAY  = 6'h24;

   localparam int unsigned CTRL_RUN_BIT = 7;
   localparam int unsigned ST_ALARM_BIT = 2;
   localparam int unsigned ST_SEC_BIT   = 4;
   localparam int unsigned ST_PER_BIT   = 7;
   localparam logic [BUS_DW-1:0] ST_MASK =
      (16'd1 << ST_ALARM_BIT) | (16'd1 << ST_SEC_BIT) | (16'd1 << ST_PER_BIT);

   typedef struct packed {
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } hms_t;

endpackage

// File: rtl/rtc_tod_count.sv
module rtc_tod_count
   import rtc_tod_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 128,
   parameter int unsigned DAY_W         = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             sub_tick_i,
   input  logic             wr_hm_i,
   input  logic             wr_sec_i,
   input  logic             wr_day_i,
   input  logic [4:0]       hr_i,
   input  logic [5:0]       mn_i,
   input  logic [5:0]       sc_i,
   input  logic [DAY_W-1:0] day_i,
   output hms_t             hms_o,
   output logic [DAY_W-1:0] day_o,
   output logic             sec_evt_o
);

   localparam int unsigned PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [DAY_W-1:0] DAY_ONE = 1;

   hms_t             hms_q, hms_nxt;
   logic [DAY_W-1:0] day_q, day_nxt;
   logic             any_wr, step, adv, sec_evt_q;

   assign any_wr = wr_hm_i | wr_sec_i | wr_day_i;
   assign step   = run_i & sub_tick_i & ~any_wr;

   generate
      if (TICKS_PER_SEC == 1) begin : g_nophase
         assign adv = step;
      end else begin : g_phase
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);
         logic [PH_W-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                ph_q <= '0;
            else if (wr_sec_i)         ph_q <= '0;
            else if (step)             ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
         end
         assign adv = step && (ph_q == PH_LAST);
      end
   endgenerate

   always_comb begin
      hms_nxt = hms_q;
      day_nxt = day_q;
      if (hms_q.sc >= 6'd59) begin
         hms_nxt.sc = '0;
         if (hms_q.mn >= 6'd59) begin
            hms_nxt.mn = '0;
            if (hms_q.hr >= 5'd23) begin
               hms_nxt.hr = '0;
               day_nxt    = day_q + DAY_ONE;
            end else begin
               hms_nxt.hr = hms_q.hr + 5'd1;
            end
         end else begin
            hms_nxt.mn = hms_q.mn + 6'd1;
         end
      end else begin
         hms_nxt.sc = hms_q.sc + 6'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hms_q     <= '0;
         day_q     <= '0;
         sec_evt_q <= 1'b0;
      end else begin
         sec_evt_q <= adv;
         if (any_wr) begin
            if (wr_hm_i) begin
               hms_q.hr <= hr_i;
               hms_q.mn <= mn_i;
            end
            if (wr_sec_i) hms_q.sc <= sc_i;
            if (wr_day_i) day_q    <= day_i;
         end else if (adv) begin
            hms_q <= hms_nxt;
            day_q <= day_nxt;
         end
      end
   end

   assign hms_o     = hms_q;
   assign day_o     = day_q;
   assign sec_evt_o = sec_evt_q;

   // R3: each second event moves the seconds field by exactly one (or wraps)
   p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt_q |-> ((hms_q.sc == $past(hms_q.sc) + 6'd1) || (hms_q.sc == 6'd0)));

   // R3: a stopped counter with no write keeps its time
   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !any_wr) |=> ($stable(hms_q) && $stable(day_q)));

endmodule

// File: rtl/rtc_tod_alarm.sv
module rtc_tod_alarm
   import rtc_tod_pkg::*;
#(
   parameter int unsigned DAY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ahm_i,
   input  logic             wr_asec_i,
   input  logic             wr_aday_i,
   input  logic [4:0]       hr_i,
   input  logic [5:0]       mn_i,
   input  logic [5:0]       sc_i,
   input  logic [DAY_W-1:0] day_i,
   input  hms_t             now_hms_i,
   input  logic [DAY_W-1:0] now_day_i,
   input  logic             sec_evt_i,
   output hms_t             ahms_o,
   output logic [DAY_W-1:0] aday_o,
   output logic             hit_o
);

   hms_t             ahms_q;
   logic [DAY_W-1:0] aday_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ahms_q <= '0;
         aday_q <= '0;
      end else begin
         if (wr_ahm_i) begin
            ahms_q.hr <= hr_i;
            ahms_q.mn <= mn_i;
         end
         if (wr_asec_i) ahms_q.sc <= sc_i;
         if (wr_aday_i) aday_q    <= day_i;
      end
   end

   // Compare only at the cycle following a second boundary
   assign hit_o  = sec_evt_i && (now_hms_i == ahms_q) && (now_day_i == aday_q);
   assign ahms_o = ahms_q;
   assign aday_o = aday_q;

endmodule

// File: rtl/rtc_tod_irq.sv
module rtc_tod_irq
   import rtc_tod_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alarm_hit_i,
   input  logic              sec_evt_i,
   input  logic              per_tick_i,
   input  logic              wr_stat_i,
   input  logic              wr_ien_i,
   input  logic [BUS_DW-1:0] wdata_i,
   output logic [BUS_DW-1:0] status_o,
   output logic [BUS_DW-1:0] enable_o,
   output logic              irq_o
);

   logic [BUS_DW-1:0] status_q, enable_q, set_v, clr_v;

   always_comb begin
      set_v               = '0;
      set_v[ST_ALARM_BIT] = alarm_hit_i;
      set_v[ST_SEC_BIT]   = sec_evt_i;
      set_v[ST_PER_BIT]   = per_tick_i;
      clr_v               = wr_stat_i ? (wdata_i & ST_MASK) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= ((status_q & ~clr_v) | set_v) & ST_MASK;
         if (wr_ien_i) enable_q <= wdata_i & ST_MASK;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
   assign irq_o    = |(status_q & enable_q);

   // R7: an alarm match always leaves the alarm flag pending
   p_alarm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit_i |=> status_q[ST_ALARM_BIT]);

   // R9: a write of one clears the second flag unless a new event arrives
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat_i && wdata_i[ST_SEC_BIT] && !sec_evt_i) |=> !status_q[ST_SEC_BIT]);

   // R10: nothing enabled, no request
   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !irq_o);

endmodule

// File: rtl/rtc_tod_regs.sv
module rtc_tod_regs
   import rtc_tod_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 128,
   parameter int unsigned DAY_W         = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sub_tick,
   input  logic        periodic_tick,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [5:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        irq
);

   generate
      if (DAY_W < 1 || DAY_W > BUS_DW) begin : g_bad_day_w
         $error("DAY_W must lie in 1..16");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   logic             wr;
   logic             wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
   logic             wr_ctrl, wr_stat, wr_ien;
   logic             run_q, sec_evt, hit;
   hms_t             hms, ahms;
   logic [DAY_W-1:0] day, aday;
   logic [15:0]      status, enable;

   assign wr      = bus_sel & bus_wr;
   assign wr_hm   = wr && (bus_addr == OFS_TIME_HM);
   assign wr_sec  = wr && (bus_addr == OFS_TIME_SEC);
   assign wr_day  = wr && (bus_addr == OFS_TIME_DAY);
   assign wr_ahm  = wr && (bus_addr == OFS_ALM_HM);
   assign wr_asec = wr && (bus_addr == OFS_ALM_SEC);
   assign wr_aday = wr && (bus_addr == OFS_ALM_DAY);
   assign wr_ctrl = wr && (bus_addr == OFS_CTRL);
   assign wr_stat = wr && (bus_addr == OFS_STAT);
   assign wr_ien  = wr && (bus_addr == OFS_IEN);

   always_ff @(posedge clk) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (wr_ctrl) run_q <= bus_wdata[CTRL_RUN_BIT];
   end

   rtc_tod_count #(.TICKS_PER_SEC(TICKS_PER_SEC), .DAY_W(DAY_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_q),
      .sub_tick_i (sub_tick),
      .wr_hm_i    (wr_hm),
      .wr_sec_i   (wr_sec),
      .wr_day_i   (wr_day),
      .hr_i       (bus_wdata[12:8]),
      .mn_i       (bus_wdata[5:0]),
      .sc_i       (bus_wdata[5:0]),
      .day_i      (bus_wdata[DAY_W-1:0]),
      .hms_o      (hms),
      .day_o      (day),
      .sec_evt_o  (sec_evt)
   );

   rtc_tod_alarm #(.DAY_W(DAY_W)) u_alarm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ahm_i   (wr_ahm),
      .wr_asec_i  (wr_asec),
      .wr_aday_i  (wr_aday),
      .hr_i       (bus_wdata[12:8]),
      .mn_i       (bus_wdata[5:0]),
      .sc_i       (bus_wdata[5:0]),
      .day_i      (bus_wdata[DAY_W-1:0]),
      .now_hms_i  (hms),
      .now_day_i  (day),
      .sec_evt_i  (sec_evt),
      .ahms_o     (ahms),
      .aday_o     (aday),
      .hit_o      (hit)
   );

   rtc_tod_irq u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .alarm_hit_i (hit),
      .sec_evt_i   (sec_evt),
      .per_tick_i  (periodic_tick),
      .wr_stat_i   (wr_stat),
      .wr_ien_i    (wr_ien),
      .wdata_i     (bus_wdata),
      .status_o    (status),
      .enable_o    (enable),
      .irq_o       (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            OFS_TIME_HM:  bus_rdata = {3'b0, hms.hr, 2'b0, hms.mn};
            OFS_TIME_SEC: bus_rdata = {10'b0, hms.sc};
            OFS_TIME_DAY: bus_rdata[DAY_W-1:0] = day;
            OFS_ALM_HM:   bus_rdata = {3'b0, ahms.hr, 2'b0, ahms.mn};
            OFS_ALM_SEC:  bus_rdata = {10'b0, ahms.sc};
            OFS_ALM_DAY:  bus_rdata[DAY_W-1:0] = aday;
            OFS_CTRL:     bus_rdata[CTRL_RUN_BIT] = run_q;
            OFS_STAT:     bus_rdata = status;
            OFS_IEN:      bus_rdata = enable;
            default:      bus_rdata = '0;
         endcase
      end
   end

   // R11: a deselected port returns zero
   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == 16'h0000));

endmodule

// File: tb/tb_rtc_tod_regs.sv
`timescale 1ns/1ps
module tb_rtc_tod_regs;

   localparam int TPS = 3;
   localparam int DW  = 9;
   localparam int DMAX = 1 << DW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sub_tick = 1'b0, periodic_tick = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   rtc_tod_regs #(.TICKS_PER_SEC(TPS), .DAY_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .periodic_tick(periodic_tick),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // behavioural reference state
   int m_sc, m_mn, m_hr, m_day, m_ph, a_sc, a_mn, a_hr, a_day;
   int m_run, m_stat, m_ien, m_sevt;
   int checks = 0, fails = 0;
   bit done = 0;
   string ph = "R1";

   function automatic int exp_rd(input bit s, input int a);
      if (!s) return 0;
      case (a)
         'h00: return (m_hr << 8) | m_mn;
         'h04: return m_sc;
         'h20: return m_day;
         'h08: return (a_hr << 8) | a_mn;
         'h0C: return a_sc;
         'h24: return a_day;
         'h10: return m_run << 7;
         'h14: return m_stat;
         'h18: return m_ien;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         'h00, 'h04, 'h20: return "R4";
         'h08, 'h0C, 'h24: return "R6";
         'h10: return "R3";
         'h14: return "R8";
         'h18: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic cyc(input bit s, input bit w, input int a, input int d,
                      input bit st, input bit pt);
      int er, clr, setv, hit;
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_addr = 6'(a); bus_wdata = 16'(d);
      sub_tick = st; periodic_tick = pt;
      #1;
      er = exp_rd(s, a);
      checks++;
      if (int'(bus_rdata) != er) begin
         fails++;
         $display("FAIL %s/%s addr=%h rdata=%h expected=%h", tag_of(a), ph, a, bus_rdata, er);
      end
      checks++;
      if (int'(irq) != (((m_stat & m_ien) != 0) ? 1 : 0)) begin
         fails++;
         $display("FAIL R10/%s irq=%0d expected=%0d", ph, irq, ((m_stat & m_ien) != 0));
      end
      @(posedge clk);
      // reference update with pre-edge state
      hit = (m_sevt && m_sc == a_sc && m_mn == a_mn && m_hr == a_hr && m_day == a_day) ? 1 : 0;
      setv = (hit << 2) | (m_sevt << 4) | (pt << 7);
      clr = (s && w && a == 'h14) ? (d & 'h94) : 0;
      m_sevt = 0;
      if (s && w && (a == 'h00 || a == 'h04 || a == 'h20)) begin
         if (a == 'h00) begin m_hr = (d >> 8) & 31; m_mn = d & 63; end
         if (a == 'h04) begin m_sc = d & 63; m_ph = 0; end
         if (a == 'h20) m_day = d & (DMAX - 1);
      end else if (m_run != 0 && st) begin
         if (m_ph == TPS - 1) begin
            m_ph = 0;
            m_sevt = 1;
            if (m_sc >= 59) begin
               m_sc = 0;
               if (m_mn >= 59) begin
                  m_mn = 0;
                  if (m_hr >= 23) begin m_hr = 0; m_day = (m_day + 1) % DMAX; end
                  else m_hr++;
               end else m_mn++;
            end else m_sc++;
         end else m_ph++;
      end
      m_stat = ((m_stat & ~clr) | setv) & 'h94;
      if (s && w) begin
         case (a)
            'h08: begin a_hr = (d >> 8) & 31; a_mn = d & 63; end
            'h0C: a_sc = d & 63;
            'h24: a_day = d & (DMAX - 1);
            'h10: m_run = (d >> 7) & 1;
            'h18: m_ien = d & 'h94;
            default: ;
         endcase
      end
   endtask

   task automatic wr(input int a, input int d);
      cyc(1, 1, a, d, 0, 0);
   endtask

   task automatic rd(input int a);
      cyc(1, 0, a, 0, 0, 0);
   endtask

   task automatic ticks(input int n, input int a);
      for (int i = 0; i < n; i++) begin
         cyc(1, 0, a, 0, 1, 0);
         rd('h04);
      end
   endtask

   initial begin
      int addrs[13] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28, 'h02, 'h3C};
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      ph = "R1";   // reset values
      foreach (addrs[i]) rd(addrs[i]);

      ph = "R2";   // packing and immediate read-back
      wr('h00, 'h0A2B); rd('h00);
      wr('h04, 30);     rd('h04);
      wr('h20, 5);      rd('h20);

      ph = "R3";   // counting only while running
      ticks(6, 'h04);
      wr('h10, 'h0080);
      ticks(9, 'h04);
      wr('h10, 'h0000);
      ticks(6, 'h00);
      wr('h10, 'h0080);

      ph = "R4";   // full carry into the day and day wrap
      wr('h20, DMAX - 1); wr('h00, 'h173B); wr('h04, 58);
      ticks(9, 'h20); rd('h00); rd('h04);
      wr('h00, 'h1F3F); wr('h04, 63);  // out-of-range fields wrap at next step
      ticks(3, 'h00); rd('h20);

      ph = "R5";   // phase restart and dropped tick on write
      wr('h04, 0);
      ticks(2, 'h04);
      wr('h04, 10);
      ticks(2, 'h04);
      ticks(1, 'h04);
      cyc(1, 1, 'h00, 'h0203, 1, 0); rd('h04);
      ticks(3, 'h04);

      ph = "R7";   // one-shot alarm
      wr('h14, 'hFFFF);
      wr('h20, 3); wr('h00, 'h0102); wr('h04, 10);
      wr('h24, 3); wr('h08, 'h0102); wr('h0C, 12);
      wr('h18, 'h0004);
      ticks(9, 'h14);
      ph = "R9";
      wr('h14, 'h0004); rd('h14);
      wr('h10, 'h0000); ticks(3, 'h14); wr('h10, 'h0080);
      ticks(6, 'h14);

      ph = "R8";   // second and periodic flags
      wr('h18, 'h0094);
      cyc(1, 0, 'h14, 0, 0, 1); rd('h14);
      wr('h14, 'hFFFF); rd('h14);
      ph = "R9";   // set wins over clear
      cyc(1, 1, 'h14, 'h0080, 0, 1); rd('h14);
      ph = "R10";
      wr('h18, 'h0000); rd('h14); wr('h18, 'hFFFF); rd('h18);

      ph = "R11";  // unmapped offsets
      wr('h1C, 'hFFFF); rd('h1C); wr('h28, 'h1234); rd('h28);
      wr('h06, 'h0FFF); rd('h04); rd('h06);
      cyc(0, 0, 'h00, 0, 0, 0);

      ph = "RND";
      for (int n = 0; n < 4000; n++) begin
         int a, d;
         bit w;
         a = addrs[$urandom_range(0, 12)];
         w = ($urandom_range(0, 5) == 0);
         d = $urandom_range(0, 16'hFFFF);
         if (a == 'h10) d = d | ($urandom_range(0, 3) != 0 ? 'h80 : 0);
         cyc($urandom_range(0, 7) != 0, w, a, d, $urandom_range(0, 1), $urandom_range(0, 15) == 0);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule